// File: doc/BRIEF.md
# Frame Buffer Auto-Fill Engine

This block fills a run of words in a 16-bit, word-addressed frame buffer RAM with one constant value, so that software does not have to write each word itself. Software programs three registers on a simple write bus: how many words to fill, the first word address, and the fill value. Writing the fill value also launches the run. The engine then issues one RAM write per clock while the RAM grant is high. It steps the address through the low eight bits, which wrap inside the 256-word region that holds the start address.

A status word on the block's output shows a busy flag. Software polls this flag and must wait for it to clear before it programs the next run. Register writes made while a run is in progress are dropped. The RAM itself and the arbitration for the RAM grant are outside the block.

Top module: `fill_engine`

## Requirements
- R1: After reset the engine is idle (status reads 0, no RAM write) and the length, start and data registers read as zero, so writing only the data register fills one word at address 0.
- R2: A write with `wr_sel` = 0 (length) or 1 (start address) updates that register but does not start a run: busy stays 0 and no RAM write is issued.
- R3: A write with `wr_sel` = 2 (data) while idle starts a run: from the next cycle busy is 1 and `mem_we` is high with `mem_addr` equal to the start address.
- R4: A length value N produces exactly N+1 accepted RAM writes, so 0 writes one word and 255 writes 256 words.
- R5: Each accepted write advances the address by one in its low 8 bits only, and the upper address bits stay unchanged, so the run wraps inside its 256-word region.
- R6: Every write of a run carries the programmed data word unchanged.
- R7: Status bit 1 is the busy flag and all other status bits read 0. Busy stays set until the last write is accepted and reads 0 in the following cycle.
- R8: A write counts as accepted only in a cycle where `mem_gnt` is high. While `mem_gnt` is low the address and data are held.
- R9: Writes to any register while busy are ignored: the running fill is unchanged and later runs use the values programmed before it.
- R10: `mem_we` is high only while the engine is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 length, 1 start address, 2 data (starts run) |
| wr_data | input | 16 | Register write value |
| status | output | 16 | Status word, bit 1 = busy |
| mem_gnt | input | 1 | RAM grant; a write is accepted when high |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | 16 | RAM write data |

## Verification
The checker watches every cycle for the local invariants. These are: no RAM write while idle, the address and data held during a stalled grant, a step of exactly one in the low byte after each accepted write, a constant data word within a run, and a run that starts or does not start according to which register was written. Some properties only the bench scenarios can show. These are the exact number of words written for a given length, the moment busy drops, the wrap points at region edges, and the fact that register writes made during a run leave no trace on later runs.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [1:0] {
    SEL_LEN   = 2'd0,
    SEL_START = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_NONE  = 2'd3
  } fill_sel_e;

  localparam int BUSY_POS = 1;
endpackage

// File: rtl/fill_regs.sv
module fill_regs
  import fill_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic [LEN_W-1:0]  len_q,
  output logic [ADDR_W-1:0] start_q,
  output logic [DATA_W-1:0] data_q,
  output logic              go
);
  logic accept;

  // register writes are only taken while idle
  assign accept = wr_en && !busy;
  assign go     = accept && (wr_sel == SEL_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= '0;
      start_q <= '0;
      data_q  <= '0;
    end else if (accept) begin
      unique case (wr_sel)
        SEL_LEN:   len_q   <= wr_data[LEN_W-1:0];
        SEL_START: start_q <= wr_data[ADDR_W-1:0];
        SEL_DATA:  data_q  <= wr_data;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/fill_seq.sv
module fill_seq #(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [LEN_W-1:0]  len_q,
  input  logic [ADDR_W-1:0] start_q,
  input  logic              gnt,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HI_W = ADDR_W - LEN_W;

  logic [LEN_W-1:0] remain;
  logic             last;

  assign last = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
      ptr    <= '0;
    end else if (go) begin
      busy   <= 1'b1;
      remain <= len_q;
      ptr    <= start_q;
    end else if (busy && gnt) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        remain <= remain - 1'b1;
        ptr    <= {ptr[ADDR_W-1 -: HI_W], ptr[LEN_W-1:0] + 1'b1};
      end
    end
  end
endmodule

// File: rtl/fill_engine.sv
module fill_engine
  import fill_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] status,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic              busy;
  logic              go;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] start_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] ptr;

  fill_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .len_q(len_q), .start_q(start_q), .data_q(data_q), .go(go)
  );

  fill_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .go(go), .len_q(len_q), .start_q(start_q),
    .gnt(mem_gnt), .busy(busy), .ptr(ptr)
  );

  always_comb begin
    status           = '0;
    status[BUSY_POS] = busy;
  end

  assign mem_we    = busy;
  assign mem_addr  = ptr;
  assign mem_wdata = data_q;
endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] status,
  input logic              mem_gnt,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  logic bsy;
  assign bsy = status[1];

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !bsy |-> !mem_we); // R10

  AST_STATUS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (status & ~16'h0002) == '0); // R7

  AST_START_ON_DATA: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2 && !bsy) |=> (bsy && mem_we)); // R3

  AST_NO_START_OTHER: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel != 2'd2 && !bsy) |=> !bsy); // R2

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_gnt) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata))); // R8

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_gnt) |=> (!mem_we ||
      (mem_addr[LEN_W-1:0] == $past(mem_addr[LEN_W-1:0]) + 1'b1 &&
       mem_addr[ADDR_W-1:LEN_W] == $past(mem_addr[ADDR_W-1:LEN_W])))); // R5

  AST_DATA_CONST: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> $stable(mem_wdata)); // R6
endmodule

bind fill_engine fill_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .status(status),
  .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/fill_engine_tb.sv
module fill_engine_tb;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd3;
  logic [15:0]   wr_data = '0;
  logic [15:0]   status;
  logic          mem_gnt = 1'b1;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;

  int n_run = 0;
  int n_fail = 0;
  int wd = 0;

  fill_engine #(.DATA_W(16), .ADDR_W(AW), .LEN_W(8)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status(status), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", wd);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  // {start[9:0], len[7:0], data[15:0], grant mode[1:0]}
  localparam logic [35:0] VEC [5] = '{
    {10'h000, 8'd0,   16'hA5A5, 2'd0},
    {10'h123, 8'd4,   16'h1234, 2'd1},
    {10'h2FC, 8'd7,   16'hBEEF, 2'd0},
    {10'h100, 8'd255, 16'h0F0F, 2'd2},
    {10'h3FF, 8'd1,   16'hFFFF, 2'd1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  // called at the negedge just after the data write edge
  task automatic run_fill(input logic [AW-1:0] st, input logic [7:0] len,
                          input logic [15:0] dat, input int mode,
                          input bit inject, input string tag);
    int cnt = 0;
    int cyc = 0;
    bit g;
    logic [AW-1:0] ea;
    chk(status == 16'h0002, "R3 R7", "busy after data write", status, 2);
    chk(mem_we && mem_addr == st, "R3", "first address", mem_addr, st);
    while (status[1] && cyc < 3000) begin
      g = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 2 == 0) : (cyc >= 3);
      if (inject && cyc >= 5 && cyc <= 7) begin
        wr_en = 1'b1;
        wr_sel = 2'(cyc - 5);
        wr_data = (cyc == 5) ? 16'h0003 : (cyc == 6) ? 16'h0300 : 16'h5555;
      end else begin
        wr_en = 1'b0; wr_sel = 2'd3;
      end
      ea = {st[AW-1:8], 8'(st[7:0] + 8'(cnt))};
      if (!mem_we) chk(1'b0, "R10", "we low while busy", 0, 1);
      else if (mem_addr != ea || mem_wdata != dat) begin
        chk(mem_addr == ea, "R5 R8", "address", mem_addr, ea);
        chk(mem_wdata == dat, "R6 R9", "data", mem_wdata, dat);
      end
      mem_gnt = g;
      if (mem_we && g) cnt++;
      @(negedge clk);
      cyc++;
    end
    wr_en = 1'b0; wr_sel = 2'd3; mem_gnt = 1'b1;
    n_run++; // address/data walk of the run counted as one check
    chk(cnt == int'(len) + 1, {tag, " R4 R7"}, "words written", cnt, int'(len) + 1);
    chk(status == 16'h0000, "R7", "busy cleared", status, 0);
    chk(!mem_we, "R10", "we after run", mem_we, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(status == 0, "R1", "status in reset", status, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(status == 0 && !mem_we, "R1", "idle after reset", {status[1], mem_we}, 0);

    // R1: only the data register written: one word at address 0
    wr(2'd2, 16'hC3C3);
    run_fill(10'h000, 8'd0, 16'hC3C3, 0, 1'b0, "R1");

    // R2: length and start writes alone start nothing
    wr(2'd0, 16'h0002);
    chk(status == 0 && !mem_we, "R2", "after length write", status, 0);
    wr(2'd1, 16'h0050);
    repeat (2) @(negedge clk);
    chk(status == 0 && !mem_we, "R2", "after start write", status, 0);

    // table walk
    foreach (VEC[i]) begin
      wr(2'd0, {8'h00, VEC[i][25:18]});
      wr(2'd1, {6'h00, VEC[i][35:26]});
      wr(2'd2, VEC[i][17:2]);
      run_fill(VEC[i][35:26], VEC[i][25:18], VEC[i][17:2], int'(VEC[i][1:0]), 1'b0, "R5 R6 R8");
    end

    // R9: register writes during a run are dropped
    wr(2'd0, 16'h0014);
    wr(2'd1, 16'h0040);
    wr(2'd2, 16'hAAAA);
    run_fill(10'h040, 8'd20, 16'hAAAA, 0, 1'b1, "R9");
    wr(2'd2, 16'h7777);
    run_fill(10'h040, 8'd20, 16'h7777, 0, 1'b0, "R9");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule